// File: doc/BRIEF.md
# Dual-Loop Phase-Frequency Detector with Lock Qualifier and Test Output Select

This block holds the digital decision logic of a two-loop frequency synthesizer. It has a main loop and an auxiliary loop. Each loop has a phase-frequency detector that watches two pulse streams. One stream comes from the reference divider and the other from the loop's own feedback divider. Both streams idle high and mark an event with a low pulse. The detector turns these events into an UP enable and a DOWN enable for an external charge pump. UP means the oscillator should speed up, and DOWN means it should slow down. Everything runs on `clk`, which is the reference input clock, so one clock period is one reference input cycle.

Each detector has two flags. A falling edge on the reference stream sets the UP flag, and a falling edge on the divider stream sets the DOWN flag. Once both flags are set, they are held for the edge on which that is seen and cleared on the next clock edge. This gives a one-cycle overlap near zero phase error and so removes the deadband. The phase error of one comparison is the number of cycles in which exactly one flag is high. A comparison is clean when that count stays below one reference cycle. A loop counts as locked after four clean comparisons in a row. A single slip removes lock on the next cycle. A disabled loop keeps its flags clear and counts as locked.

A two-bit selector picks what drives one registered test pin. It can show the combined lock, the main reference stream (inverted so it idles low), the auxiliary divider stream, or the main divider stream.

Top module: `pd_phase_lock`

## Requirements
- R1: A falling edge (1 to 0, sampled on `clk`) of a loop's reference stream sets that loop's UP output, and a falling edge of its divider stream sets its DOWN output. Each becomes visible after the clock edge that samples the low level.
- R2: After a clock edge at which both UP and DOWN of a loop are high, both are low after the next clock edge. With coincident falling edges, each is high for exactly one cycle.
- R3: If the reference edge leads the divider edge by d cycles (d > 0), UP is high for d+1 cycles and DOWN for 1 cycle. If the divider edge leads by d cycles, DOWN is high for d+1 cycles and UP for 1 cycle.
- R4: A comparison is clean only if UP and DOWN are never high alone during it, which means a phase error of less than one reference cycle. Any comparison that is not clean restarts that loop's qualification count at zero.
- R5: `lockOut` rises after an enabled loop completes its fourth clean comparison in a row, provided the other loop is also qualified or disabled. `lockOut` falls on the cycle after the first cycle with UP and DOWN unequal on an enabled loop.
- R6: While a loop's enable is 0, its UP and DOWN stay low, it counts as locked, and its qualification count is cleared. After it is re-enabled it must again complete four clean comparisons. With both loops disabled, `lockOut` is 1.
- R7: `testSel` = 2'b00 drives `testOut` with the lock signal.
- R8: `testSel` = 2'b01 drives `testOut` with the inverse of `refMainN`, so the output idles low and pulses high.
- R9: `testSel` = 2'b10 drives `testOut` with `divAuxN`, and `testSel` = 2'b11 drives it with `divMainN`. Both idle high and pulse low.
- R10: `testOut` is registered. The value seen in a cycle reflects the selector and its source as they were in the previous cycle.
- R11: During and after reset (`rstN` low, asynchronous), all UP/DOWN outputs, `lockOut` and `testOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference input clock, one period per reference cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| enMain | input | 1 | Main loop enable |
| enAux | input | 1 | Auxiliary loop enable |
| refMainN | input | 1 | Reference pulse stream for the main loop, idles high |
| divMainN | input | 1 | Main divider pulse stream, idles high |
| refAuxN | input | 1 | Reference pulse stream for the auxiliary loop, idles high |
| divAuxN | input | 1 | Auxiliary divider pulse stream, idles high |
| testSel | input | 2 | Test output source: 00 lock, 01 reference, 10 aux divider, 11 main divider |
| upMain | output | 1 | Main loop raise-frequency enable |
| dnMain | output | 1 | Main loop lower-frequency enable |
| upAux | output | 1 | Auxiliary loop raise-frequency enable |
| dnAux | output | 1 | Auxiliary loop lower-frequency enable |
| lockOut | output | 1 | Both enabled loops qualified as locked |
| testOut | output | 1 | Registered test pin |

## Verification
UP and DOWN change one edge after the edge that samples a falling level. They clear one edge after the edge where both are seen high. The qualification count and `lockOut` follow one edge after that, and `testOut` lags its source by one edge. The bench therefore runs fixed ten-cycle comparison periods: the reference edge falls in cycle 3 and the divider edge falls at cycle 3 plus an offset of -3 to +3. Every settle point then falls before the last sample of the period.

The bench samples on falling clock edges. It totals UP/DOWN widths across the whole period and reads `lockOut` at the period's last sample. In the targeted slip case it checks `lockOut` at the exact sample before and after the drop. For `testOut`, it compares each sample with the source recorded one cycle earlier.

// File: rtl/pd_lock_pkg.sv
package pd_lock_pkg;

  localparam int LOOP_MAIN = 0;
  localparam int LOOP_AUX  = 1;
  localparam int NUM_LOOPS = 2;

  // Strobes a detector datapath hands to the lock control each cycle.
  typedef struct packed {
    logic done;   // both flags set: comparison ends at this edge
    logic clean;  // accumulated single-flag time below the slip limit
    logic slip;   // single-flag time reaches the slip limit this cycle
  } pdStrobe_t;

  typedef enum logic [1:0] {
    SEL_LOCK = 2'b00,
    SEL_REF  = 2'b01,
    SEL_AUX  = 2'b10,
    SEL_MAIN = 2'b11
  } testSel_e;

endpackage

// File: rtl/pd_pfd_core.sv
module pd_pfd_core
  import pd_lock_pkg::*;
#(
  parameter int SLIP_LIMIT = 1,
  parameter int EXCESS_MAX = 7
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      en,
  input  logic      refN,
  input  logic      divN,
  output logic      up,
  output logic      dn,
  output pdStrobe_t strobe
);

  localparam int EXCESS_W = $clog2(EXCESS_MAX + 1);
  localparam logic [EXCESS_W-1:0] EXCESS_TOP = EXCESS_W'(EXCESS_MAX);

  logic refPrevQ, divPrevQ;
  logic upQ, dnQ;
  logic [EXCESS_W-1:0] excessQ;
  logic refFall, divFall, bothSet, oneSet;

  // Edge detection against the level seen at the previous edge.
  assign refFall = refPrevQ & ~refN;
  assign divFall = divPrevQ & ~divN;
  assign bothSet = upQ & dnQ;
  assign oneSet  = upQ ^ dnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPrevQ <= 1'b1;
      divPrevQ <= 1'b1;
    end else begin
      refPrevQ <= refN;
      divPrevQ <= divN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upQ     <= 1'b0;
      dnQ     <= 1'b0;
      excessQ <= '0;
    end else if (!en || bothSet) begin
      upQ     <= 1'b0;
      dnQ     <= 1'b0;
      excessQ <= '0;
    end else begin
      upQ <= upQ | refFall;
      dnQ <= dnQ | divFall;
      if (oneSet && excessQ != EXCESS_TOP) excessQ <= excessQ + 1'b1;
    end
  end

  assign up = upQ;
  assign dn = dnQ;

  always_comb begin
    strobe.done  = en & bothSet;
    strobe.clean = int'(excessQ) < SLIP_LIMIT;
    strobe.slip  = en & oneSet & ((int'(excessQ) + 1) >= SLIP_LIMIT);
  end

endmodule

// File: rtl/pd_lock_ctrl.sv
module pd_lock_ctrl
  import pd_lock_pkg::*;
#(
  parameter int LOOPS       = NUM_LOOPS,
  parameter int LOCK_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LOOPS-1:0]      en,
  input  pdStrobe_t [LOOPS-1:0] strobes,
  output logic                  lock
);

  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LOCK_CYCLES);

  logic [LOOPS-1:0] loopOk;
  logic lockQ;

  for (genvar g = 0; g < LOOPS; g++) begin : g_loop
    logic [CNT_W-1:0] cntQ, cntD;

    always_comb begin
      cntD = cntQ;
      if (!en[g] || strobes[g].slip) begin
        cntD = '0;
      end else if (strobes[g].done) begin
        if (!strobes[g].clean)   cntD = '0;
        else if (cntQ != CNT_TOP) cntD = cntQ + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cntQ <= '0;
      else       cntQ <= cntD;
    end

    assign loopOk[g] = !en[g] || (cntD == CNT_TOP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockQ <= 1'b0;
    else       lockQ <= &loopOk;
  end

  assign lock = lockQ;

endmodule

// File: rtl/pd_test_sel.sv
module pd_test_sel
  import pd_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] sel,
  input  logic       lock,
  input  logic       refN,
  input  logic       auxDivN,
  input  logic       mainDivN,
  output logic       testOut
);

  testSel_e selE;
  logic pick, outQ;

  assign selE = testSel_e'(sel);

  always_comb begin
    unique case (selE)
      SEL_LOCK: pick = lock;
      SEL_REF:  pick = ~refN;
      SEL_AUX:  pick = auxDivN;
      SEL_MAIN: pick = mainDivN;
      default:  pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outQ <= 1'b0;
    else       outQ <= pick;
  end

  assign testOut = outQ;

endmodule

// File: rtl/pd_phase_lock.sv
module pd_phase_lock
  import pd_lock_pkg::*;
#(
  parameter int LOCK_CYCLES = 4,
  parameter int SLIP_LIMIT  = 1,
  parameter int EXCESS_MAX  = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enMain,
  input  logic       enAux,
  input  logic       refMainN,
  input  logic       divMainN,
  input  logic       refAuxN,
  input  logic       divAuxN,
  input  logic [1:0] testSel,
  output logic       upMain,
  output logic       dnMain,
  output logic       upAux,
  output logic       dnAux,
  output logic       lockOut,
  output logic       testOut
);

  logic [NUM_LOOPS-1:0] enVec, refVec, divVec, upVec, dnVec;
  pdStrobe_t [NUM_LOOPS-1:0] strobes;
  logic lockInt;

  assign enVec[LOOP_MAIN]  = enMain;
  assign enVec[LOOP_AUX]   = enAux;
  assign refVec[LOOP_MAIN] = refMainN;
  assign refVec[LOOP_AUX]  = refAuxN;
  assign divVec[LOOP_MAIN] = divMainN;
  assign divVec[LOOP_AUX]  = divAuxN;

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_pfd
    pd_pfd_core #(
      .SLIP_LIMIT(SLIP_LIMIT),
      .EXCESS_MAX(EXCESS_MAX)
    ) core_i (
      .clk   (clk),
      .rstN  (rstN),
      .en    (enVec[g]),
      .refN  (refVec[g]),
      .divN  (divVec[g]),
      .up    (upVec[g]),
      .dn    (dnVec[g]),
      .strobe(strobes[g])
    );
  end

  pd_lock_ctrl #(
    .LOOPS      (NUM_LOOPS),
    .LOCK_CYCLES(LOCK_CYCLES)
  ) lock_i (
    .clk    (clk),
    .rstN   (rstN),
    .en     (enVec),
    .strobes(strobes),
    .lock   (lockInt)
  );

  pd_test_sel sel_i (
    .clk     (clk),
    .rstN    (rstN),
    .sel     (testSel),
    .lock    (lockInt),
    .refN    (refMainN),
    .auxDivN (divAuxN),
    .mainDivN(divMainN),
    .testOut (testOut)
  );

  assign upMain  = upVec[LOOP_MAIN];
  assign dnMain  = dnVec[LOOP_MAIN];
  assign upAux   = upVec[LOOP_AUX];
  assign dnAux   = dnVec[LOOP_AUX];
  assign lockOut = lockInt;

endmodule

// File: rtl/pd_phase_lock_chk.sv
module pd_phase_lock_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enMain,
  input logic       enAux,
  input logic       refMainN,
  input logic       divMainN,
  input logic       divAuxN,
  input logic [1:0] testSel,
  input logic       upMain,
  input logic       dnMain,
  input logic       upAux,
  input logic       dnAux,
  input logic       lockOut,
  input logic       testOut
);

  assert_main_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (upMain && dnMain) |=> (!upMain && !dnMain));

  assert_aux_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (upAux && dnAux) |=> (!upAux && !dnAux));

  assert_aux_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !enAux |=> (!upAux && !dnAux));

  assert_main_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !enMain |=> (!upMain && !dnMain));

  assert_both_off_lock_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!enMain && !enAux) |=> lockOut);

  assert_slip_unlock_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enMain && (upMain ^ dnMain)) |=> !lockOut);

  assert_sel_lock_R7: assert property (@(posedge clk) disable iff (!rstN)
    (testSel == 2'b00) |=> (testOut == $past(lockOut)));

  assert_sel_ref_R8: assert property (@(posedge clk) disable iff (!rstN)
    (testSel == 2'b01) |=> (testOut == !$past(refMainN)));

  assert_sel_div_R9: assert property (@(posedge clk) disable iff (!rstN)
    (testSel == 2'b11) |=> (testOut == $past(divMainN)));

  assert_sel_aux_R9: assert property (@(posedge clk) disable iff (!rstN)
    (testSel == 2'b10) |=> (testOut == $past(divAuxN)));

endmodule

bind pd_phase_lock pd_phase_lock_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .enMain  (enMain),
  .enAux   (enAux),
  .refMainN(refMainN),
  .divMainN(divMainN),
  .divAuxN (divAuxN),
  .testSel (testSel),
  .upMain  (upMain),
  .dnMain  (dnMain),
  .upAux   (upAux),
  .dnAux   (dnAux),
  .lockOut (lockOut),
  .testOut (testOut)
);

// File: tb/pd_phase_lock_tb_top.sv
module pd_phase_lock_tb_top;

  localparam int PERIOD   = 10;
  localparam int REF_SLOT = 3;
  localparam int QUALIFY  = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, enMain, enAux, refMainN, divMainN, refAuxN, divAuxN;
  logic [1:0] testSel;
  logic upMain, dnMain, upAux, dnAux, lockOut, testOut;

  pd_phase_lock dut_i (
    .clk(clk), .rstN(rstN), .enMain(enMain), .enAux(enAux),
    .refMainN(refMainN), .divMainN(divMainN), .refAuxN(refAuxN), .divAuxN(divAuxN),
    .testSel(testSel), .upMain(upMain), .dnMain(dnMain), .upAux(upAux), .dnAux(dnAux),
    .lockOut(lockOut), .testOut(testOut)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int goodM = 0;
  int goodA = 0;
  bit pValid = 0;
  logic pRefM, pDivM, pDivA, pLock;
  logic [1:0] pSel;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expUp(int d);
    return (d > 0) ? d + 1 : 1;
  endfunction

  function automatic int expDn(int d);
    return (d < 0) ? 1 - d : 1;
  endfunction

  // One comparison period: reference falls in cycle REF_SLOT, divider at REF_SLOT+d.
  task automatic runPeriod(int dM, int dA, logic [1:0] sel, bit dropCheck);
    int cUpM = 0, cDnM = 0, cUpA = 0, cDnA = 0;
    bit lockExp;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      cUpM += int'(upMain); cDnM += int'(dnMain);
      cUpA += int'(upAux);  cDnA += int'(dnAux);
      if (pValid) begin
        logic e;
        case (pSel)
          2'b00: e = pLock;
          2'b01: e = ~pRefM;
          2'b10: e = pDivA;
          default: e = pDivM;
        endcase
        check(testOut == e, (pSel == 2'b00) ? "R7 R10" : (pSel == 2'b01) ? "R8 R10" : "R9 R10",
              "testOut", int'(testOut), int'(e));
      end
      if (dropCheck && i == REF_SLOT + 1)
        check(lockOut == 1'b1, "R5", "lock held before slip seen", int'(lockOut), 1);
      if (dropCheck && i == REF_SLOT + 2)
        check(lockOut == 1'b0, "R5", "lock dropped after slip", int'(lockOut), 0);
      pLock = lockOut;
      refMainN = (i == REF_SLOT) ? 1'b0 : 1'b1;
      divMainN = (i == REF_SLOT + dM) ? 1'b0 : 1'b1;
      refAuxN  = (i == REF_SLOT) ? 1'b0 : 1'b1;
      divAuxN  = (i == REF_SLOT + dA) ? 1'b0 : 1'b1;
      testSel  = sel;
      pRefM = refMainN; pDivM = divMainN; pDivA = divAuxN; pSel = sel; pValid = 1;
    end
    if (enMain) begin
      check(cUpM == expUp(dM), "R1 R3", "upMain width", cUpM, expUp(dM));
      check(cDnM == expDn(dM), "R1 R3", "dnMain width", cDnM, expDn(dM));
      goodM = (dM == 0) ? ((goodM < QUALIFY) ? goodM + 1 : QUALIFY) : 0;
    end else begin
      check(cUpM + cDnM == 0, "R6", "main flags while disabled", cUpM + cDnM, 0);
      goodM = 0;
    end
    if (enAux) begin
      check(cUpA == expUp(dA), "R1 R3", "upAux width", cUpA, expUp(dA));
      check(cDnA == expDn(dA), "R1 R3", "dnAux width", cDnA, expDn(dA));
      goodA = (dA == 0) ? ((goodA < QUALIFY) ? goodA + 1 : QUALIFY) : 0;
    end else begin
      check(cUpA + cDnA == 0, "R6", "aux flags while disabled", cUpA + cDnA, 0);
      goodA = 0;
    end
    lockExp = (!enMain || goodM == QUALIFY) && (!enAux || goodA == QUALIFY);
    check(lockOut == lockExp, "R4 R5", "lock at period end", int'(lockOut), int'(lockExp));
  endtask

  initial begin
    rstN = 1'b0; enMain = 1'b1; enAux = 1'b1;
    refMainN = 1'b1; divMainN = 1'b1; refAuxN = 1'b1; divAuxN = 1'b1; testSel = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({upMain, dnMain, upAux, dnAux, lockOut, testOut} == 6'b0, "R11", "outputs in reset",
          int'({upMain, dnMain, upAux, dnAux, lockOut, testOut}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check({upMain, dnMain, upAux, dnAux, lockOut, testOut} == 6'b0, "R11", "outputs after reset",
          int'({upMain, dnMain, upAux, dnAux, lockOut, testOut}), 0);

    // R2 R5: aligned edges qualify lock on the fourth clean comparison
    for (int k = 0; k < 5; k++) runPeriod(0, 0, 2'b00, 1'b0);
    // R5: first slip drops lock on the next cycle
    runPeriod(1, 0, 2'b00, 1'b1);
    // R3 R4 R7 R8 R9: full offset sweep with rotating test selection
    for (int a = -3; a <= 3; a++)
      for (int b = -3; b <= 3; b++)
        runPeriod(a, b, 2'((a + 3) * 7 + b + 3), 1'b0);
    for (int k = 0; k < 6; k++) runPeriod(0, 0, 2'(k), 1'b0);
    // R6: disabled aux loop is ignored and counts as locked
    enAux = 1'b0;
    for (int k = 0; k < 4; k++) runPeriod(0, 2, 2'b00, 1'b0);
    // R6: re-enabled aux must requalify
    enAux = 1'b1;
    for (int k = 0; k < 5; k++) runPeriod(0, 0, 2'b00, 1'b0);
    // R6: both loops off means lock
    enMain = 1'b0; enAux = 1'b0;
    for (int k = 0; k < 2; k++) runPeriod(2, -2, 2'b00, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule